// File: doc/BRIEF.md
# DMA Write Frame Sequencer

This block runs the host side of a host-to-device DMA write. After a start request carrying the transfer size in bytes, it converts that size into payload words and cuts the payload into data frames. Each frame holds the remaining word count or the per-frame cap, whichever is smaller. The cap is 2048 words by default. Each frame goes to the transmit path as a single stream: a header word carrying the data-frame type code, followed by the payload words. The payload words are taken one at a time from a source handshake and passed through without buffering.

The device gates each frame with an activate event, which the receive dispatcher delivers as a one-cycle pulse. A start request can carry an auto-activate flag; when it is set, the first frame goes out without waiting for an activate. Every frame after the first always waits for one. After a frame has been sent, the block waits for the link layer's transmit status. A good status leads either to the next frame or to a one-cycle completion pulse. A bad status ends the transfer with an error flag, which stays high until the next accepted start. If the byte count does not fill the last word, the unused upper bytes of that word are sent as zeros.

Top module: `dma_wr_seq`

## Requirements
- R1: After reset, tx_valid_o, src_ready_o, done_o, err_o and busy_o are all low.
- R2: A start with a nonzero byte count and auto_act_i low makes busy_o high. No word is offered on tx_valid_o until an act_evt_i pulse has been received.
- R3: A start with auto_act_i high offers the first frame header in the cycle after the start. Every later frame still waits for its own act_evt_i pulse.
- R4: Each frame begins with one header word. For that word, tx_sof_o is high, tx_eof_o is low, and tx_data_o equals 46h, with the type code in bits 7:0 and every other bit zero.
- R5: The transfer carries ceil(bytes/4) payload words in total. Each frame carries min(remaining words, MAX_FRAME_WORDS) of them, and tx_eof_o marks the last payload word of every frame.
- R6: On the final payload word of the transfer, if bytes mod 4 = t is nonzero, only the lowest t bytes (byte 0 at bits 7:0) keep the source value and the upper bytes are zero. Every other word passes unchanged.
- R7: During the payload phase, tx_valid_o follows src_valid_i and src_ready_o follows tx_ready_i. A word moves only when both are high, and a stall holds the current word in place.
- R8: After each frame, nothing is offered until status_valid_i arrives. A good status on the last frame makes done_o high for exactly one cycle, after which busy_o falls. A good status with words still remaining makes the block wait for an activate again.
- R9: A status pulse with status_ok_i low makes err_o high and busy_o low from the next cycle. err_o stays high until a start with a nonzero byte count is accepted, and that start clears it.
- R10: An act_evt_i pulse outside the wait-for-activate phase, or a status_valid_i pulse outside the wait-for-status phase, has no effect.
- R11: A start_i while busy_o is high is ignored. A start with a zero byte count is ignored: busy_o stays low and done_o does not pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request pulse |
| xfer_bytes_i | input | LEN_W | Transfer size in bytes, sampled with start_i |
| auto_act_i | input | 1 | First frame needs no activate, sampled with start_i |
| act_evt_i | input | 1 | Activate received from device (pulse) |
| status_valid_i | input | 1 | Transmit status report from link layer (pulse) |
| status_ok_i | input | 1 | Transmit status good when high |
| src_valid_i | input | 1 | Payload source has a word |
| src_data_i | input | DATA_W | Payload source word |
| src_ready_o | output | 1 | Payload word taken this cycle when src_valid_i is high |
| tx_valid_o | output | 1 | Frame word offered to transmit path |
| tx_data_o | output | DATA_W | Frame word (header or payload) |
| tx_sof_o | output | 1 | Offered word is the frame header |
| tx_eof_o | output | 1 | Offered word is the last of the frame |
| tx_ready_i | input | 1 | Transmit path accepts the offered word |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Transfer ended on a bad status |
| busy_o | output | 1 | Transfer in progress |

## Verification
Two pairs of events can collide in one cycle. An activate pulse can land in the same cycle as a payload word handshake, and an activate pulse can arrive together with the good status that closes a frame. The bench creates both collisions on every frame of a sweep over byte counts 1 to 40, with and without auto-activate, using a small frame cap of 4 words. A stray activate must neither cut the running frame short nor let the next frame skip its own activate. The bench judges this by the exact count of words in each frame, by the eof position, and by checking that nothing is offered in the cycles before the activate that the bench itself issues.

// File: rtl/dma_wr_pkg.sv
package dma_wr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE         = 3'd0,
        ST_WAIT_ACT     = 3'd1,
        ST_SEND_HDR     = 3'd2,
        ST_SEND_PAYLOAD = 3'd3,
        ST_WAIT_STATUS  = 3'd4,
        ST_DONE         = 3'd5,
        ST_ERROR        = 3'd6
    } seq_state_e;

    localparam logic [7:0] DATA_FRAME_CODE = 8'h46;

endpackage

// File: rtl/dma_wr_word_count.sv
module dma_wr_word_count #(
    parameter int LEN_W  = 24,
    parameter int BPW_W  = 2,
    parameter int WORD_W = LEN_W - BPW_W + 1
) (
    input  logic [LEN_W-1:0]  bytes_i,
    output logic [WORD_W-1:0] words_o,
    output logic [BPW_W-1:0]  tail_o
);
    localparam int BPW = 1 << BPW_W;

    logic [LEN_W:0] rounded;

    // Round up to whole words before dropping the byte-lane bits.
    assign rounded = {1'b0, bytes_i} + (LEN_W + 1)'(BPW - 1);
    assign words_o = rounded[LEN_W:BPW_W];
    assign tail_o  = bytes_i[BPW_W-1:0];

endmodule

// File: rtl/dma_wr_frame_len.sv
module dma_wr_frame_len #(
    parameter int WORD_W    = 23,
    parameter int FLEN_W    = 12,
    parameter int MAX_WORDS = 2048
) (
    input  logic [WORD_W-1:0] rem_i,
    output logic [FLEN_W-1:0] len_o
);
    localparam logic [WORD_W-1:0] CAP = WORD_W'(MAX_WORDS);

    always_comb begin
        if (rem_i > CAP) begin
            len_o = FLEN_W'(MAX_WORDS);
        end else begin
            len_o = rem_i[FLEN_W-1:0];
        end
    end

endmodule

// File: rtl/dma_wr_tail_pad.sv
module dma_wr_tail_pad #(
    parameter int DATA_W = 32,
    parameter int BPW_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_i,
    input  logic [BPW_W-1:0]  tail_i,
    input  logic              is_last_i,
    output logic [DATA_W-1:0] data_o
);
    localparam int BPW = DATA_W / 8;

    for (genvar g = 0; g < BPW; g++) begin : g_lane
        logic keep;
        assign keep = !is_last_i || (tail_i == '0) || (BPW_W'(g) < tail_i);
        assign data_o[8*g +: 8] = keep ? data_i[8*g +: 8] : 8'h00;
    end

    // R6
    top_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_last_i && (tail_i != '0)) |-> (data_o[DATA_W-1 -: 8] == 8'h00));

endmodule

// File: rtl/dma_wr_seq.sv
module dma_wr_seq
    import dma_wr_pkg::*;
#(
    parameter int DATA_W          = 32,
    parameter int LEN_W           = 24,
    parameter int MAX_FRAME_WORDS = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  xfer_bytes_i,
    input  logic              auto_act_i,
    input  logic              act_evt_i,
    input  logic              status_valid_i,
    input  logic              status_ok_i,
    input  logic              src_valid_i,
    input  logic [DATA_W-1:0] src_data_i,
    output logic              src_ready_o,
    output logic              tx_valid_o,
    output logic [DATA_W-1:0] tx_data_o,
    output logic              tx_sof_o,
    output logic              tx_eof_o,
    input  logic              tx_ready_i,
    output logic              done_o,
    output logic              err_o,
    output logic              busy_o
);
    localparam int BPW    = DATA_W / 8;
    localparam int BPW_W  = $clog2(BPW);
    localparam int WORD_W = LEN_W - BPW_W + 1;
    localparam int FLEN_W = $clog2(MAX_FRAME_WORDS + 1);

    typedef struct packed {
        seq_state_e         st;
        logic [WORD_W-1:0]  rem;
        logic [FLEN_W-1:0]  beats;
        logic [BPW_W-1:0]   tail;
        logic               err;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [WORD_W-1:0] start_words;
    logic [BPW_W-1:0]  start_tail;
    logic [FLEN_W-1:0] frame_len;
    logic [DATA_W-1:0] padded;
    logic              hdr_fire;
    logic              pay_fire;
    logic              last_beat;

    dma_wr_word_count #(
        .LEN_W (LEN_W),
        .BPW_W (BPW_W),
        .WORD_W(WORD_W)
    ) u_words (
        .bytes_i(xfer_bytes_i),
        .words_o(start_words),
        .tail_o (start_tail)
    );

    dma_wr_frame_len #(
        .WORD_W   (WORD_W),
        .FLEN_W   (FLEN_W),
        .MAX_WORDS(MAX_FRAME_WORDS)
    ) u_flen (
        .rem_i(r_q.rem),
        .len_o(frame_len)
    );

    dma_wr_tail_pad #(
        .DATA_W(DATA_W),
        .BPW_W (BPW_W)
    ) u_pad (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_i   (src_data_i),
        .tail_i   (r_q.tail),
        .is_last_i(r_q.rem == WORD_W'(1)),
        .data_o   (padded)
    );

    assign hdr_fire  = (r_q.st == ST_SEND_HDR) && tx_ready_i;
    assign pay_fire  = (r_q.st == ST_SEND_PAYLOAD) && src_valid_i && tx_ready_i;
    assign last_beat = (r_q.beats == FLEN_W'(1));

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE, ST_ERROR: begin
                if (start_i && (start_words != '0)) begin
                    r_d.err  = 1'b0;
                    r_d.rem  = start_words;
                    r_d.tail = start_tail;
                    r_d.st   = auto_act_i ? ST_SEND_HDR : ST_WAIT_ACT;
                end
            end
            ST_WAIT_ACT: begin
                if (act_evt_i) begin
                    r_d.st = ST_SEND_HDR;
                end
            end
            ST_SEND_HDR: begin
                if (hdr_fire) begin
                    r_d.beats = frame_len;
                    r_d.st    = ST_SEND_PAYLOAD;
                end
            end
            ST_SEND_PAYLOAD: begin
                if (pay_fire) begin
                    r_d.rem   = r_q.rem - WORD_W'(1);
                    r_d.beats = r_q.beats - FLEN_W'(1);
                    if (last_beat) begin
                        r_d.st = ST_WAIT_STATUS;
                    end
                end
            end
            ST_WAIT_STATUS: begin
                if (status_valid_i) begin
                    if (!status_ok_i) begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_ERROR;
                    end else if (r_q.rem == '0) begin
                        r_d.st = ST_DONE;
                    end else begin
                        r_d.st = ST_WAIT_ACT;
                    end
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, rem: '0, beats: '0, tail: '0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_valid_o  = (r_q.st == ST_SEND_HDR) ||
                         ((r_q.st == ST_SEND_PAYLOAD) && src_valid_i);
    assign tx_data_o   = (r_q.st == ST_SEND_HDR) ? {{(DATA_W-8){1'b0}}, DATA_FRAME_CODE}
                                                 : padded;
    assign tx_sof_o    = (r_q.st == ST_SEND_HDR);
    assign tx_eof_o    = (r_q.st == ST_SEND_PAYLOAD) && src_valid_i && last_beat;
    assign src_ready_o = (r_q.st == ST_SEND_PAYLOAD) && tx_ready_i;
    assign done_o      = (r_q.st == ST_DONE);
    assign err_o       = r_q.err;
    assign busy_o      = (r_q.st != ST_IDLE) && (r_q.st != ST_ERROR);

    // Payload words seen since the last accepted header, kept for the cap check.
    logic [FLEN_W:0] mon_beats_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_beats_q <= '0;
        end else if (tx_valid_o && tx_ready_i) begin
            mon_beats_q <= tx_sof_o ? '0 : mon_beats_q + 1'b1;
        end
    end

    // R5
    frame_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && tx_ready_i && !tx_sof_o) |-> (mon_beats_q < (FLEN_W + 1)'(MAX_FRAME_WORDS)));

    // R4
    header_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sof_o |-> (tx_valid_o && !tx_eof_o && (tx_data_o[7:0] == DATA_FRAME_CODE)));

    // R2
    hold_until_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT_ACT) |-> !tx_valid_o);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R8
    done_after_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(status_valid_i && status_ok_i));

    // R9
    err_on_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_WAIT_STATUS) && status_valid_i && !status_ok_i) |=> (err_o && !busy_o));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !start_i) |=> err_o);

    // R8
    no_done_with_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

endmodule

// File: tb/dma_wr_seq_tb.sv
module dma_wr_seq_tb_top;
    localparam int DW   = 32;
    localparam int LW   = 8;
    localparam int MAXW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start_i;
    logic [LW-1:0] xfer_bytes_i;
    logic          auto_act_i;
    logic          act_evt_i;
    logic          status_valid_i;
    logic          status_ok_i;
    logic          src_valid_i;
    logic [DW-1:0] src_data_i;
    logic          src_ready_o;
    logic          tx_valid_o;
    logic [DW-1:0] tx_data_o;
    logic          tx_sof_o;
    logic          tx_eof_o;
    logic          tx_ready_i;
    logic          done_o;
    logic          err_o;
    logic          busy_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    dma_wr_seq #(
        .DATA_W         (DW),
        .LEN_W          (LW),
        .MAX_FRAME_WORDS(MAXW)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .xfer_bytes_i  (xfer_bytes_i),
        .auto_act_i    (auto_act_i),
        .act_evt_i     (act_evt_i),
        .status_valid_i(status_valid_i),
        .status_ok_i   (status_ok_i),
        .src_valid_i   (src_valid_i),
        .src_data_i    (src_data_i),
        .src_ready_o   (src_ready_o),
        .tx_valid_o    (tx_valid_o),
        .tx_data_o     (tx_data_o),
        .tx_sof_o      (tx_sof_o),
        .tx_eof_o      (tx_eof_o),
        .tx_ready_i    (tx_ready_i),
        .done_o        (done_o),
        .err_o         (err_o),
        .busy_o        (busy_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int k);
        return 32'(k) * 32'h01030507 + 32'h80402010;
    endfunction

    function automatic logic [31:0] exp_word(input int k, input int w, input int b);
        logic [31:0] v;
        int t;
        v = pat(k);
        t = b % 4;
        if (k == w - 1 && t != 0) v = v & ((32'h1 << (8 * t)) - 32'h1);
        return v;
    endfunction

    task automatic idle_inputs();
        start_i = 0; xfer_bytes_i = '0; auto_act_i = 0; act_evt_i = 0;
        status_valid_i = 0; status_ok_i = 0; src_valid_i = 0; src_data_i = '0;
        tx_ready_i = 0;
    endtask

    // Runs one transfer acting as device, payload source and transmit path.
    task automatic run_xfer(input int b, input bit auto_a, input bit bad_first);
        int w, k, rem, ph, beats;
        bit first;
        w = (b + 3) / 4; k = 0; rem = w; beats = 0; first = 1;
        @(negedge clk);
        start_i = 1; xfer_bytes_i = LW'(b); auto_act_i = auto_a;
        @(negedge clk);
        start_i = 0; xfer_bytes_i = '0; auto_act_i = 0;
        chk(busy_o == 1'b1, "R2", "busy after start", busy_o, 1);
        chk(err_o == 1'b0, "R9", "err cleared by start", err_o, 0);
        ph = auto_a ? 1 : 0;
        forever begin
            cyc++;
            if (ph == 0) begin
                chk(tx_valid_o == 1'b0, "R2", "offer before activate", tx_valid_o, 0);
                status_valid_i = 1; status_ok_i = 1; start_i = 1; xfer_bytes_i = LW'(7);
                @(negedge clk);
                status_valid_i = 0; status_ok_i = 0; start_i = 0; xfer_bytes_i = '0;
                chk(tx_valid_o == 1'b0 && busy_o == 1'b1, "R11", "stray start/status while waiting",
                    {tx_valid_o, busy_o}, 2'b01);
                act_evt_i = 1;
                @(negedge clk);
                act_evt_i = 0;
                ph = 1;
            end else if (ph == 1) begin
                tx_ready_i = ((cyc * 7 + b) % 5) != 0;
                #1;
                chk(tx_valid_o == 1'b1, (first && auto_a) ? "R3" : "R4", "header offered", tx_valid_o, 1);
                if (tx_ready_i) begin
                    chk(tx_sof_o && !tx_eof_o && tx_data_o == 32'h46, "R4", "header word",
                        {tx_sof_o, tx_eof_o, tx_data_o}, {2'b10, 32'h46});
                    beats = (rem > MAXW) ? MAXW : rem;
                    ph = 2;
                end
                @(negedge clk);
                tx_ready_i = 0;
                first = 0;
            end else if (ph == 2) begin
                tx_ready_i  = ((cyc * 7 + b) % 5) != 0;
                src_valid_i = ((cyc * 3 + b) % 4) != 0;
                src_data_i  = pat(k);
                act_evt_i   = (cyc % 2) == 0;
                #1;
                chk(src_ready_o == tx_ready_i && tx_valid_o == src_valid_i, "R7", "payload handshake",
                    {src_ready_o, tx_valid_o}, {tx_ready_i, src_valid_i});
                if (src_valid_i && tx_ready_i) begin
                    chk(tx_data_o == exp_word(k, w, b), (k == w - 1 && b % 4 != 0) ? "R6" : "R5",
                        "payload word", tx_data_o, exp_word(k, w, b));
                    chk(tx_eof_o == (beats == 1) && !tx_sof_o, "R5", "eof position",
                        {tx_sof_o, tx_eof_o}, {1'b0, beats == 1});
                    k++; rem--; beats--;
                    if (beats == 0) ph = 3;
                end
                @(negedge clk);
                act_evt_i = 0; src_valid_i = 0; tx_ready_i = 0;
            end else begin
                tx_ready_i = 1; src_valid_i = 1;
                #1;
                chk(tx_valid_o == 1'b0, "R8", "quiet while awaiting status", tx_valid_o, 0);
                @(negedge clk);
                tx_ready_i = 0; src_valid_i = 0;
                status_valid_i = 1; status_ok_i = !bad_first; act_evt_i = 1;
                @(negedge clk);
                status_valid_i = 0; status_ok_i = 0; act_evt_i = 0;
                if (bad_first) begin
                    chk(err_o && !busy_o && !done_o, "R9", "bad status", {err_o, busy_o, done_o}, 3'b100);
                    return;
                end
                if (rem == 0) begin
                    chk(done_o == 1'b1, "R8", "done pulse", done_o, 1);
                    @(negedge clk);
                    chk(done_o == 1'b0 && busy_o == 1'b0, "R8", "done single, idle", {done_o, busy_o}, 0);
                    chk(k == w, "R5", "total words", k, w);
                    return;
                end
                ph = 0;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R8 watchdog actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        tx_ready_i = 1;
        #1;
        chk(!tx_valid_o && !src_ready_o && !done_o && !err_o && !busy_o, "R1", "reset state",
            {tx_valid_o, src_ready_o, done_o, err_o, busy_o}, 0);
        rst_n = 1;
        @(negedge clk);
        tx_ready_i = 0;
        #1;
        chk(!tx_valid_o && !busy_o, "R1", "after reset release", {tx_valid_o, busy_o}, 0);

        // Zero-length start is ignored.
        @(negedge clk);
        start_i = 1; xfer_bytes_i = '0;
        @(negedge clk);
        start_i = 0;
        for (int i = 0; i < 3; i++) begin
            chk(!busy_o && !done_o && !tx_valid_o, "R11", "zero length ignored",
                {busy_o, done_o, tx_valid_o}, 0);
            @(negedge clk);
        end

        for (int b = 1; b <= 40; b++) begin
            for (int a = 0; a < 2; a++) begin
                run_xfer(b, a[0], 1'b0);
            end
        end

        // Error path and stickiness.
        run_xfer(20, 1'b0, 1'b1);
        for (int i = 0; i < 3; i++) begin
            act_evt_i = (i == 1);
            status_valid_i = (i == 2); status_ok_i = 1;
            @(negedge clk);
            act_evt_i = 0; status_valid_i = 0; status_ok_i = 0;
            chk(err_o && !busy_o && !tx_valid_o, "R10", "stray events in error",
                {err_o, busy_o, tx_valid_o}, 3'b100);
        end
        start_i = 1; xfer_bytes_i = '0;
        @(negedge clk);
        start_i = 0;
        chk(err_o && !busy_o, "R9", "zero start keeps error", {err_o, busy_o}, 2'b10);
        run_xfer(9, 1'b0, 1'b0);
        run_xfer(13, 1'b1, 1'b1);
        run_xfer(17, 1'b1, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule